// File: doc/BRIEF.md
# I2C General-Call Receiver

This block is the target-side receive engine of a status-code style I2C peripheral, limited to the general call. It watches SCL and SDA through synchronisers and recognises the all-zero address with the write bit. It acknowledges that address and then takes in data bytes, acknowledging each one or not as firmware has set up. Every event stops the bus. The engine raises an interrupt flag, loads an 8-bit status code and holds SCL low until firmware clears the flag.

Firmware uses a small register port. Offset 0 is control, offset 1 is status and offset 2 is the last received byte. Through control, firmware enables general-call recognition, chooses ACK or NAK for the next byte and clears the flag. It can also leave a request to generate a START once the bus is free, and release that START again. Outputs drive open-drain lines through output-enable signals.

Top module: `i2c_gc_rx`

## Requirements
- R1: After reset the status register reads 0xF8, the interrupt flag is 0, and neither SCL nor SDA is pulled low.
- R2: An address byte of 0x00 (write bit 0) is acknowledged only while general-call enable (control bit 0) and the acknowledge-enable bit (control bit 2) are both 1. When it is acknowledged, the flag is set after the ninth clock and status 0x70 is loaded. Any other byte, or either bit at 0, gets no ACK and no flag.
- R3: If the arbitration-lost input pulsed before the general call is acknowledged, status 0x78 is loaded instead of 0x70. The pulse affects only the next such address.
- R4: A data byte received with the acknowledge-enable bit at 1 is ACKed and gives status 0x90. The byte, shifted in MSB first, is readable at offset 2, and the engine stays addressed for more bytes.
- R5: A data byte received with the acknowledge-enable bit at 0 is NAKed and gives status 0x98, with the byte readable at offset 2. Later bytes get no ACK and raise no flag until the next START.
- R6: A STOP or a repeated START while addressed sets the flag with status 0xA0. A STOP while not addressed raises nothing.
- R7: SCL is pulled low for as long as the flag is set and is released once it is cleared.
- R8: A control write with bit 3 at 0 clears the flag and returns status to 0xF8. A write with bit 3 at 1 leaves the flag alone. Control reads back general-call enable in bit 0, acknowledge-enable in bit 2, the flag in bit 3 and a pending START request in bit 5.
- R9: A START request (control bit 5) pulls SDA low and raises start_o only when the bus is free and the flag is clear. Writing control bit 4 as 1 releases SDA and drops start_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset (0 control, 1 status, 2 data) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt flag |
| arb_lost_i | input | 1 | Pulse: arbitration was lost as master |
| start_o | output | 1 | A requested START is being held on the bus |

## Verification
Two things can land on the same clock: a STOP that frees the bus, and a START request that firmware left pending while the bus was busy. The bench arms the request after a NAKed byte, while the bus is still busy, and confirms that SDA stays released. It then issues the STOP and confirms that the engine pulls SDA low and raises start_o only after the STOP. The same request is also armed after a 0xA0 event with the flag left set, and the bench checks that it waits for the flag to be cleared before acting.

// File: rtl/gcs_pkg.sv
package gcs_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] GC_ADDR = '0;

    // status codes
    localparam logic [7:0] ST_GC_ACK  = 8'h70;
    localparam logic [7:0] ST_GC_ARB  = 8'h78;
    localparam logic [7:0] ST_DAT_ACK = 8'h90;
    localparam logic [7:0] ST_DAT_NAK = 8'h98;
    localparam logic [7:0] ST_END     = 8'hA0;
    localparam logic [7:0] ST_NONE    = 8'hF8;

    // register offsets and control bit positions
    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_DATA = 2'd2;
    localparam int CB_GC  = 0;
    localparam int CB_AA  = 2;
    localparam int CB_SI  = 3;
    localparam int CB_STO = 4;
    localparam int CB_STA = 5;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_AACK, PH_DATA, PH_DACK, PH_SKIP
    } phase_e;

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] dat;
        logic [7:0]        stat;
        logic              si;
        logic              aa;
        logic              gc;
        logic              sta;
        logic              hold_m;
        logic              busy;
        logic              ack_drv;
        logic              seen9;
        logic              ack_ok;
        logic              arb;
    } eng_t;

    localparam eng_t ENG_RST = '{
        phase: PH_IDLE, cnt: '0, shreg: '0, dat: '0, stat: ST_NONE,
        si: 1'b0, aa: 1'b0, gc: 1'b0, sta: 1'b0, hold_m: 1'b0,
        busy: 1'b0, ack_drv: 1'b0, seen9: 1'b0, ack_ok: 1'b0, arb: 1'b0
    };

endpackage

// File: rtl/gcs_sync.sv
module gcs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '1;
                else        chain_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '1;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gcs_cond.sv
module gcs_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s_i,
    input  logic sda_s_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_s_i;
            sda_p_q <= sda_s_i;
        end
    end

    assign scl_rise_o = scl_s_i & ~scl_p_q;
    assign scl_fall_o = ~scl_s_i & scl_p_q;
    // SDA edges only count while SCL stays high
    assign start_o    = scl_s_i & scl_p_q & sda_p_q & ~sda_s_i;
    assign stop_o     = scl_s_i & scl_p_q & ~sda_p_q & sda_s_i;
endmodule

// File: rtl/i2c_gc_rx.sv
module i2c_gc_rx
    import gcs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe_o,
    output logic       sda_oe_o,
    input  logic       reg_we_i,
    input  logic [1:0] reg_addr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    output logic       irq_o,
    input  logic       arb_lost_i,
    output logic       start_o
);
    logic [1:0] raw_w, syn_w;
    logic       scl_rise, scl_fall, start_det, stop_det;

    assign raw_w = {scl_i, sda_i};

    gcs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_w),
        .q_o   (syn_w)
    );

    gcs_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s_i    (syn_w[1]),
        .sda_s_i    (syn_w[0]),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    eng_t q, d;

    logic              addressed;
    logic              byte_done;
    logic [BYTE_W-1:0] next_byte;
    logic              unused_wbits;

    assign addressed    = (q.phase == PH_DATA) || (q.phase == PH_DACK);
    assign byte_done    = (q.cnt == CNT_W'(BYTE_W - 1));
    assign next_byte    = {q.shreg[BYTE_W-2:0], syn_w[0]};
    assign unused_wbits = ^{reg_wdata_i[7:6], reg_wdata_i[1]};

    always_comb begin
        d = q;

        // firmware writes
        if (reg_we_i && reg_addr_i == RA_CTRL) begin
            d.gc  = reg_wdata_i[CB_GC];
            d.aa  = reg_wdata_i[CB_AA];
            d.sta = reg_wdata_i[CB_STA];
            if (!reg_wdata_i[CB_SI]) begin
                d.si   = 1'b0;
                d.stat = ST_NONE;
            end
            if (reg_wdata_i[CB_STO]) d.hold_m = 1'b0;
        end
        if (arb_lost_i) d.arb = 1'b1;

        // pending START once the bus is free and no event is open
        if (q.sta && !q.busy && !q.si && !q.hold_m) begin
            d.hold_m = 1'b1;
            d.sta    = 1'b0;
        end

        // bus events; a hardware flag set wins over a same-cycle clear
        if (stop_det) begin
            d.busy    = 1'b0;
            d.phase   = PH_IDLE;
            d.ack_drv = 1'b0;
            if (addressed) begin
                d.si   = 1'b1;
                d.stat = ST_END;
            end
        end else if (start_det) begin
            d.busy    = 1'b1;
            d.phase   = PH_ADDR;
            d.cnt     = '0;
            d.ack_drv = 1'b0;
            if (addressed) begin
                d.si   = 1'b1;
                d.stat = ST_END;
            end
        end else if (scl_rise) begin
            unique case (q.phase)
                PH_ADDR: begin
                    d.shreg = next_byte;
                    d.cnt   = q.cnt + 1'b1;
                    if (byte_done) begin
                        d.seen9 = 1'b0;
                        if (next_byte == GC_ADDR && q.gc && q.aa) begin
                            d.phase  = PH_AACK;
                            d.ack_ok = 1'b1;
                        end else begin
                            d.phase = PH_SKIP;
                        end
                    end
                end
                PH_DATA: begin
                    d.shreg = next_byte;
                    d.cnt   = q.cnt + 1'b1;
                    if (byte_done) begin
                        d.phase  = PH_DACK;
                        d.ack_ok = q.aa;
                        d.seen9  = 1'b0;
                    end
                end
                PH_AACK, PH_DACK: d.seen9 = 1'b1;
                default: ;
            endcase
        end else if (scl_fall) begin
            unique case (q.phase)
                PH_AACK: begin
                    if (q.seen9) begin
                        d.ack_drv = 1'b0;
                        d.si      = 1'b1;
                        d.stat    = q.arb ? ST_GC_ARB : ST_GC_ACK;
                        d.arb     = 1'b0;
                        d.phase   = PH_DATA;
                        d.cnt     = '0;
                    end else begin
                        d.ack_drv = 1'b1;
                    end
                end
                PH_DACK: begin
                    if (q.seen9) begin
                        d.ack_drv = 1'b0;
                        d.si      = 1'b1;
                        d.dat     = q.shreg;
                        d.cnt     = '0;
                        if (q.ack_ok) begin
                            d.stat  = ST_DAT_ACK;
                            d.phase = PH_DATA;
                        end else begin
                            d.stat  = ST_DAT_NAK;
                            d.phase = PH_SKIP;
                        end
                    end else begin
                        d.ack_drv = q.ack_ok;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ENG_RST;
        else        q <= d;
    end

    assign scl_oe_o = q.si;
    assign sda_oe_o = q.ack_drv | q.hold_m;
    assign irq_o    = q.si;
    assign start_o  = q.hold_m;

    always_comb begin
        unique case (reg_addr_i)
            RA_CTRL: reg_rdata_o = {2'b00, q.sta, 1'b0, q.si, q.aa, 1'b0, q.gc};
            RA_STAT: reg_rdata_o = q.stat;
            RA_DATA: reg_rdata_o = q.dat;
            default: reg_rdata_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/gcs_chk.sv
module gcs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_i,
    input logic       sda_oe_i,
    input logic       start_i,
    input logic [7:0] stat_i,
    input logic       gc_aa_i,
    input logic       cond_i
);
    // R2
    gc_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_i) && stat_i == 8'h70) |-> $past(gc_aa_i));

    // R4
    data_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_i) && stat_i == 8'h90) |-> $past(sda_oe_i));

    // R5
    data_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_i) && stat_i == 8'h98) |-> !$past(sda_oe_i));

    // R6
    end_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_i) && stat_i == 8'hA0) |-> $past(cond_i));

    // R8
    flag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i == (stat_i != 8'hF8));

    // R9
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_i) |-> $past(!irq_i));

    // R9
    start_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> sda_oe_i);
endmodule

bind i2c_gc_rx gcs_chk u_gcs_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_i    (irq_o),
    .sda_oe_i (sda_oe_o),
    .start_i  (start_o),
    .stat_i   (q.stat),
    .gc_aa_i  (q.gc & q.aa),
    .cond_i   (start_det | stop_det)
);

// File: tb/test_i2c_gc_rx.sv
`timescale 1ns/1ps
module test_i2c_gc_rx;
    localparam int H = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       scl_line, sda_line;
    logic       scl_oe_o, sda_oe_o, irq_o, start_o;
    logic       reg_we_i = 1'b0;
    logic [1:0] reg_addr_i = 2'd1;
    logic [7:0] reg_wdata_i = 8'h00;
    logic [7:0] reg_rdata_o;
    logic       arb_lost_i = 1'b0;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    assign scl_line = scl_m & ~scl_oe_o;
    assign sda_line = sda_m & ~sda_oe_o;

    i2c_gc_rx i_i2c_gc_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_line),
        .sda_i       (sda_line),
        .scl_oe_o    (scl_oe_o),
        .sda_oe_o    (sda_oe_o),
        .reg_we_i    (reg_we_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o),
        .arb_lost_i  (arb_lost_i),
        .start_o     (start_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        reg_we_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = v;
        @(negedge clk);
        reg_we_i = 1'b0; reg_addr_i = 2'd1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr_i = a;
        #1 v = reg_rdata_o;
    endtask

    task automatic scl_up();
        scl_m = 1'b1;
        tick(1);
        while (!scl_line) tick(1);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_up(); tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H);
        scl_up(); tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick(H);
        scl_up(); tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(H);
            scl_up(); tick(H);
            scl_m = 1'b0; tick(2);
        end
        sda_m = 1'b1; tick(H);
        scl_up(); tick(H);
        ack = !sda_line;
        scl_m = 1'b0; tick(H);
    endtask

    // expect flag and code, then clear with the given control value
    task automatic expect_event(input logic [7:0] code, input string req, input logic [7:0] clr);
        logic [7:0] v;
        rd(2'd1, v);
        chk(irq_o && v == code, req, v, code);
        wr(clr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        bit ack;
        tick(3);
        rst_n = 1'b1;
        tick(3);

        // R1 reset state
        rd(2'd1, v);
        chk(v == 8'hF8, "R1 status", v, 8'hF8);
        chk(!irq_o && !scl_oe_o && !sda_oe_o, "R1 outputs idle", {irq_o, scl_oe_o, sda_oe_o}, 0);

        // R8 control readback
        wr(8'h05);
        rd(2'd0, v);
        chk(v == 8'h05, "R8 ctrl readback", v, 8'h05);

        // R2 sweep of every address byte with GC and AA set
        for (int a = 0; a < 256; a++) begin
            bus_start();
            send_byte(8'(a), ack);
            chk(ack == (a == 0), "R2 address ack", ack, a == 0);
            if (a == 0) begin
                rd(2'd1, v);
                chk(irq_o && v == 8'h70, "R2 gc status", v, 8'h70);
                tick(20);
                chk(scl_oe_o && !scl_line, "R7 scl held", scl_line, 0);
                wr(8'h05);
                rd(2'd1, v);
                chk(!irq_o && v == 8'hF8, "R8 clear", v, 8'hF8);
                tick(4);
                chk(!scl_oe_o, "R7 scl released", scl_oe_o, 0);
                bus_stop();
                expect_event(8'hA0, "R6 stop addressed", 8'h05);
            end else begin
                chk(!irq_o, "R2 no flag", irq_o, 0);
                bus_stop();
                chk(!irq_o, "R6 stop unaddressed", irq_o, 0);
            end
        end

        // R2 enable combinations
        for (int c = 0; c < 3; c++) begin
            logic [7:0] cv;
            cv = (c == 0) ? 8'h04 : (c == 1) ? 8'h01 : 8'h00;
            wr(cv);
            bus_start();
            send_byte(8'h00, ack);
            chk(!ack && !irq_o, "R2 disabled no ack", {ack, irq_o}, 0);
            bus_stop();
            chk(!irq_o, "R6 stop unaddressed", irq_o, 0);
        end
        wr(8'h05);

        // R4 data sweep, R5 NAK then ignore
        bus_start();
        send_byte(8'h00, ack);
        expect_event(8'h70, "R2 gc status", 8'h05);
        for (int i = 0; i < 66; i++) begin
            logic [7:0] dv;
            dv = (i == 64) ? 8'h00 : (i == 65) ? 8'hFF : 8'((i * 37 + 5) & 255);
            send_byte(dv, ack);
            chk(ack, "R4 data ack", ack, 1);
            rd(2'd2, v);
            chk(v == dv, "R4 data value", v, dv);
            expect_event(8'h90, "R4 status", (i == 65) ? 8'h01 : 8'h05);
        end
        send_byte(8'h3C, ack);
        chk(!ack, "R5 nak", ack, 0);
        rd(2'd2, v);
        chk(v == 8'h3C, "R5 data value", v, 8'h3C);
        expect_event(8'h98, "R5 status", 8'h05);
        send_byte(8'hC3, ack);
        chk(!ack && !irq_o, "R5 ignored after nak", {ack, irq_o}, 0);
        rd(2'd2, v);
        chk(v == 8'h3C, "R5 data unchanged", v, 8'h3C);
        bus_stop();
        chk(!irq_o, "R6 stop after nak", irq_o, 0);

        // R6 repeated start while addressed, then new general call
        bus_start();
        send_byte(8'h00, ack);
        expect_event(8'h70, "R2 gc status", 8'h05);
        send_byte(8'hA5, ack);
        expect_event(8'h90, "R4 status", 8'h05);
        bus_rstart();
        expect_event(8'hA0, "R6 repeated start", 8'h05);
        send_byte(8'h00, ack);
        chk(ack, "R6 address after rstart", ack, 1);
        expect_event(8'h70, "R2 gc after rstart", 8'h05);
        bus_stop();
        expect_event(8'hA0, "R6 stop addressed", 8'h05);

        // R3 arbitration lost, one-shot
        @(negedge clk); arb_lost_i = 1'b1;
        @(negedge clk); arb_lost_i = 1'b0;
        bus_start();
        send_byte(8'h00, ack);
        expect_event(8'h78, "R3 arb status", 8'h05);
        bus_stop();
        expect_event(8'hA0, "R6 stop addressed", 8'h05);
        bus_start();
        send_byte(8'h00, ack);
        expect_event(8'h70, "R3 flag consumed", 8'h05);
        bus_stop();
        expect_event(8'hA0, "R6 stop addressed", 8'h05);

        // R9 request while bus busy after a NAK
        bus_start();
        send_byte(8'h00, ack);
        expect_event(8'h70, "R2 gc status", 8'h01);
        send_byte(8'h11, ack);
        expect_event(8'h98, "R5 status", 8'h25);
        tick(20);
        chk(!start_o && !sda_oe_o, "R9 wait bus busy", start_o, 0);
        bus_stop();
        tick(6);
        chk(start_o && sda_oe_o && !sda_line, "R9 start after stop", start_o, 1);
        wr(8'h15);
        tick(6);
        chk(!start_o && !sda_oe_o, "R9 release", start_o, 0);

        // R9 request with flag still set after 0xA0
        bus_start();
        send_byte(8'h00, ack);
        expect_event(8'h70, "R2 gc status", 8'h05);
        bus_stop();
        rd(2'd1, v);
        chk(irq_o && v == 8'hA0, "R6 stop addressed", v, 8'hA0);
        wr(8'h2D);
        tick(10);
        chk(irq_o && !start_o, "R9 wait flag", start_o, 0);
        rd(2'd0, v);
        chk(v == 8'h2D, "R8 ctrl with flag and request", v, 8'h2D);
        wr(8'h25);
        tick(6);
        chk(start_o && sda_oe_o, "R9 start after clear", start_o, 1);
        wr(8'h15);
        tick(6);
        chk(!start_o && !sda_oe_o, "R9 release", start_o, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule